// File: doc/BRIEF.md
# Mask-Based Branch Condition Resolver

This block settles, in one clocked stage, whether a conditional branch goes and where execution continues. It compares a 2-bit condition code left behind by an earlier operation against a 4-bit selection mask taken from the branch instruction. Each mask bit stands for one condition-code value. The branch goes when the bit belonging to the current code is set. A mask of zero therefore acts as a no-op, and a mask of all ones branches unconditionally.

Two instruction forms are handled. In the register form, the target is the address held in one register. A register field of zero in this form suppresses the branch. In the storage form, the target is a 12-bit unsigned displacement added to a base register and an index register. A register number of zero in either field adds nothing. The sum wraps to a 24-bit address. The surrounding pipeline performs the register reads and supplies both the register numbers and the values read. When the branch does not go, the supplied sequential address passes through unchanged.

Top module: `branch_resolver`

## Requirements
- R1: While `rstN` is low, `taken` is 0 and `nextAddr` is 0.
- R2: The mask bit for condition code c is `maskIn[3-c]`, which is the bit of value 8>>c. Code 0 (equal/zero) uses value 8, code 1 (low/minus) uses 4, code 2 (high/plus) uses 2 and code 3 (overflow) uses 1. A branch is taken exactly when that bit is set and the form does not suppress it.
- R3: A mask of 0 never produces `taken`, for any code and either form.
- R4: A mask of 15 always produces `taken` in the storage form, and in the register form whenever `rsNum` is nonzero.
- R5: Combined masks branch on any selected code. Mask 7 goes on codes 1, 2 and 3 but not on 0. Mask 11 skips only code 1. Mask 13 skips only code 2.
- R6: In the register form (`formSel`=0), a taken branch sets `nextAddr` to `rsVal`.
- R7: In the register form, `rsNum`=0 means not taken, whatever the mask.
- R8: In the storage form (`formSel`=1), a taken branch sets `nextAddr` to the 24-bit wrapped sum of the zero-extended `dispIn`, the base contribution and the index contribution.
- R9: In the storage form, `rsNum`=0 makes the base contribution 0, and `rxNum`=0 makes the index contribution 0, regardless of `rsVal` and `rxVal`.
- R10: When the branch is not taken, `nextAddr` equals `seqAddr`.
- R11: The outputs reflect the inputs sampled at the previous rising edge of `clk`, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| ccIn | input | 2 | Current condition code |
| maskIn | input | 4 | Branch selection mask; the leftmost bit belongs to code 0 |
| formSel | input | 1 | 0 = register form, 1 = storage form |
| rsNum | input | 4 | Register number: the target register (register form) or the base register (storage form) |
| rsVal | input | 24 | Address value read from register `rsNum` |
| rxNum | input | 4 | Index register number (storage form only) |
| rxVal | input | 24 | Address value read from register `rxNum` |
| dispIn | input | 12 | Unsigned displacement (storage form only) |
| seqAddr | input | 24 | Sequential next-instruction address |
| taken | output | 1 | Branch taken, registered |
| nextAddr | output | 24 | Next instruction address, registered |

## Verification
The assertions assume that every input is known and settled at each rising edge of `clk`. They also assume that `formSel` alone decides how the register fields are read, so a value port paired with register number zero may hold anything. The stimulus changes inputs only on falling edges. It draws register values, displacements and sequential addresses at random, together with values of `rsVal` and `rxVal` that are nonzero while their register number is zero. This checks that the zero-register rule holds against real data rather than against a value that happens to be zero. Directed cases cover every code under masks 0, 15, 7, 11 and 13, and sums that wrap past 24 bits.

// File: rtl/brres_pkg.sv
package brres_pkg;

  // Strobes from the control decode to the address datapath
  typedef struct packed {
    logic takeBranch;  // branch goes this cycle
    logic useStorage;  // storage form: base + index + displacement
    logic zeroBase;    // base field names register zero
    logic zeroIndex;   // index field names register zero
  } ctlStrobes_t;

endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
#(
  parameter int CC_W   = 2,
  parameter int RNUM_W = 4
) (
  input  logic [CC_W-1:0]        ccIn,
  input  logic [(1<<CC_W)-1:0]   maskIn,
  input  logic                   formSel,
  input  logic [RNUM_W-1:0]      rsNum,
  input  logic [RNUM_W-1:0]      rxNum,
  output ctlStrobes_t            strobes
);

  localparam int MASK_W = 1 << CC_W;

  logic [MASK_W-1:0] hitVec;
  logic              condMet;
  logic              rsIsZero;
  logic              rxIsZero;

  // Each mask bit, counted from the left, pairs with one code value
  for (genvar i = 0; i < MASK_W; i++) begin : g_hit
    assign hitVec[i] = maskIn[MASK_W-1-i] && (ccIn == CC_W'(i));
  end

  assign condMet  = |hitVec;
  assign rsIsZero = (rsNum == '0);
  assign rxIsZero = (rxNum == '0);

  always_comb begin
    strobes            = '0;
    strobes.useStorage = formSel;
    strobes.zeroBase   = rsIsZero;
    strobes.zeroIndex  = rxIsZero;
    if (formSel) begin
      strobes.takeBranch = condMet;
    end else begin
      // register form: register field zero suppresses the branch
      strobes.takeBranch = condMet && !rsIsZero;
    end
  end

endmodule

// File: rtl/brres_dpath.sv
module brres_dpath
  import brres_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] rxVal,
  input  logic [DISP_W-1:0] dispIn,
  input  logic [ADDR_W-1:0] seqAddr,
  output logic              takenQ,
  output logic [ADDR_W-1:0] nextAddrQ
);

  localparam int N_OPND = 2;
  localparam int PAD_W  = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] opndRaw  [N_OPND];
  logic [N_OPND-1:0] opndZero;
  logic [ADDR_W-1:0] opndEff  [N_OPND];
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] storageTgt;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] nextAddrD;

  assign opndRaw[0] = rsVal;
  assign opndRaw[1] = rxVal;
  assign opndZero   = {strobes.zeroIndex, strobes.zeroBase};

  // Register number zero contributes nothing to the address sum
  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    assign opndEff[k] = opndZero[k] ? '0 : opndRaw[k];
  end

  assign dispExt    = {{PAD_W{1'b0}}, dispIn};
  assign storageTgt = dispExt + opndEff[0] + opndEff[1];
  assign branchTgt  = strobes.useStorage ? storageTgt : rsVal;
  assign nextAddrD  = strobes.takeBranch ? branchTgt : seqAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ    <= 1'b0;
      nextAddrQ <= '0;
    end else begin
      takenQ    <= strobes.takeBranch;
      nextAddrQ <= nextAddrD;
    end
  end

  // R10
  fallthru_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeBranch |=> (nextAddrQ == $past(seqAddr)));

  // R6
  reg_form_tgt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeBranch && !strobes.useStorage) |=> (nextAddrQ == $past(rsVal)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!takenQ && nextAddrQ == '0));

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int CC_W   = 2,
  parameter int RNUM_W = 4,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CC_W-1:0]      ccIn,
  input  logic [(1<<CC_W)-1:0] maskIn,
  input  logic                 formSel,
  input  logic [RNUM_W-1:0]    rsNum,
  input  logic [ADDR_W-1:0]    rsVal,
  input  logic [RNUM_W-1:0]    rxNum,
  input  logic [ADDR_W-1:0]    rxVal,
  input  logic [DISP_W-1:0]    dispIn,
  input  logic [ADDR_W-1:0]    seqAddr,
  output logic                 taken,
  output logic [ADDR_W-1:0]    nextAddr
);

  localparam int MASK_W = 1 << CC_W;

  ctlStrobes_t strobes;

  brres_ctrl #(
    .CC_W   (CC_W),
    .RNUM_W (RNUM_W)
  ) u_ctrl (
    .ccIn    (ccIn),
    .maskIn  (maskIn),
    .formSel (formSel),
    .rsNum   (rsNum),
    .rxNum   (rxNum),
    .strobes (strobes)
  );

  brres_dpath #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rsVal     (rsVal),
    .rxVal     (rxVal),
    .dispIn    (dispIn),
    .seqAddr   (seqAddr),
    .takenQ    (taken),
    .nextAddrQ (nextAddr)
  );

  // R3
  never_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskIn == '0) |=> !taken);

  // R4
  always_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((maskIn == '1) && formSel) |=> taken);

  // R7
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!formSel && rsNum == '0) |=> (!taken && nextAddr == $past(seqAddr)));

  // R2
  code_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (formSel && maskIn[MASK_W-1-int'(ccIn)]) |=> taken);

endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  ccIn = '0;
  logic [3:0]  maskIn = '0;
  logic        formSel = 1'b0;
  logic [3:0]  rsNum = '0;
  logic [23:0] rsVal = '0;
  logic [3:0]  rxNum = '0;
  logic [23:0] rxVal = '0;
  logic [11:0] dispIn = '0;
  logic [23:0] seqAddr = '0;
  logic        taken;
  logic [23:0] nextAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  branch_resolver uut (
    .clk(clk), .rstN(rstN), .ccIn(ccIn), .maskIn(maskIn), .formSel(formSel),
    .rsNum(rsNum), .rsVal(rsVal), .rxNum(rxNum), .rxVal(rxVal),
    .dispIn(dispIn), .seqAddr(seqAddr), .taken(taken), .nextAddr(nextAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Expected outcome derived from R2, R3, R4, R5, R7
  function automatic bit expTaken(input logic [1:0] cc, input logic [3:0] m,
                                  input logic f, input logic [3:0] rn);
    bit hit;
    hit = m[3 - cc];
    if (!f && rn == 4'd0) return 1'b0;
    return hit;
  endfunction

  // Expected address from R6, R8, R9, R10
  function automatic logic [23:0] expAddr(input bit tk, input logic f,
      input logic [3:0] rn, input logic [23:0] rv, input logic [3:0] xn,
      input logic [23:0] xv, input logic [11:0] d, input logic [23:0] sq);
    logic [23:0] b;
    logic [23:0] x;
    if (!tk) return sq;
    if (!f) return rv;
    b = (rn == 4'd0) ? 24'd0 : rv;
    x = (xn == 4'd0) ? 24'd0 : xv;
    return 24'(b + x + {12'd0, d});
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge (R11)
  task automatic step(input string tag, input logic [1:0] c, input logic [3:0] m,
      input logic f, input logic [3:0] rn, input logic [23:0] rv,
      input logic [3:0] xn, input logic [23:0] xv, input logic [11:0] d,
      input logic [23:0] sq);
    bit tk;
    ccIn = c; maskIn = m; formSel = f; rsNum = rn; rsVal = rv;
    rxNum = xn; rxVal = xv; dispIn = d; seqAddr = sq;
    tk = expTaken(c, m, f, rn);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " taken"}, {23'd0, taken}, {23'd0, tk});
    chk({tag, " addr"}, nextAddr, expAddr(tk, f, rn, rv, xn, xv, d, sq));
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));

    // R1: reset state while inputs ask for a taken branch
    ccIn = 2'd0; maskIn = 4'hF; formSel = 1'b1; seqAddr = 24'h123456;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 taken", {23'd0, taken}, 24'd0);
    chk("R1 addr", nextAddr, 24'd0);
    rstN = 1'b1;

    // R2: single-bit masks against every code
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        step("R2", 2'(c), 4'(8 >> b), 1'b1, 4'd3, 24'h000100, 4'd5,
             24'h000020, 12'h004, 24'h0A0000);

    // R3 and R4: never and always masks, both forms
    for (int c = 0; c < 4; c++) begin
      step("R3", 2'(c), 4'h0, 1'b1, 4'd2, 24'h111111, 4'd4, 24'h222222, 12'hFFF, 24'h00BEEF);
      step("R3", 2'(c), 4'h0, 1'b0, 4'd2, 24'h111111, 4'd4, 24'h222222, 12'hFFF, 24'h00BEEF);
      step("R4", 2'(c), 4'hF, 1'b1, 4'd2, 24'h111111, 4'd4, 24'h222222, 12'h010, 24'h00BEEF);
      step("R4", 2'(c), 4'hF, 1'b0, 4'd9, 24'hABCDEF, 4'd4, 24'h222222, 12'h010, 24'h00BEEF);
    end

    // R5: combined masks 7, 11, 13 on every code
    for (int c = 0; c < 4; c++) begin
      step("R5", 2'(c), 4'd7,  1'b0, 4'd1, 24'h400000, 4'd0, 24'h0, 12'h0, 24'h000004);
      step("R5", 2'(c), 4'd11, 1'b0, 4'd1, 24'h400000, 4'd0, 24'h0, 12'h0, 24'h000004);
      step("R5", 2'(c), 4'd13, 1'b0, 4'd1, 24'h400000, 4'd0, 24'h0, 12'h0, 24'h000004);
    end

    // R6: register form target
    step("R6", 2'd2, 4'd2, 1'b0, 4'd14, 24'hFEDCBA, 4'd7, 24'h333333, 12'h123, 24'h000010);
    // R7: register zero suppresses even an always mask
    step("R7", 2'd0, 4'hF, 1'b0, 4'd0, 24'h777777, 4'd7, 24'h333333, 12'h123, 24'h000020);
    // R8: wrap past 24 bits
    step("R8", 2'd3, 4'd1, 1'b1, 4'd6, 24'hFFFF00, 4'd8, 24'h000080, 12'hFFF, 24'h000030);
    // R9: base zero, index zero, both zero, with nonzero values
    step("R9", 2'd0, 4'd8, 1'b1, 4'd0, 24'h555555, 4'd8, 24'h000100, 12'h00A, 24'h000040);
    step("R9", 2'd0, 4'd8, 1'b1, 4'd3, 24'h000200, 4'd0, 24'h666666, 12'h00B, 24'h000050);
    step("R9", 2'd0, 4'd8, 1'b1, 4'd0, 24'h555555, 4'd0, 24'h666666, 12'hABC, 24'h000060);
    // R10: not-taken storage form returns sequential address
    step("R10", 2'd1, 4'd8, 1'b1, 4'd3, 24'h000200, 4'd4, 24'h000300, 12'h00B, 24'hC0FFEE);

    // Random mix: R2 R6 R8 R9 R10 R11
    for (int n = 0; n < 3000; n++) begin
      step("R11 random", 2'($urandom), 4'($urandom), 1'($urandom),
           ($urandom % 4 == 0) ? 4'd0 : 4'($urandom),
           24'($urandom),
           ($urandom % 4 == 0) ? 4'd0 : 4'($urandom),
           24'($urandom), 12'($urandom), 24'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule